// File: doc/BRIEF.md
# Transmit FIFO Watermark and Interrupt Unit

This block holds the transmit queue of a serial peripheral and gathers the events around it into one interrupt request. A producer pushes words into a power-of-two deep FIFO, and the shifter on the other side pops them. A programmable low-water level marks the point where the queue needs refilling. Four event sources feed a sticky status vector:

- the queue holding fewer entries than the low-water level,
- a push refused because the queue is full,
- a non-zero receive occupancy, which arrives as an input,
- a mode-fault pulse.

Software clears status bits by writing ones. It turns sources on and off through separate enable and disable strobes, and reads the resulting mask back. The interrupt line is high whenever a latched status bit is also enabled.

The threshold register holds only log2(DEPTH) bits. Writing all ones and reading the value back therefore returns DEPTH-1, which lets software find the queue depth. Register access is one set of decoded write strobes sharing a data bus, plus a read select.

Top module: `txwm_irq_unit`

## Requirements
- R1: While reset is active the status reads 0, the mask reads ENA_RST (default 0x06), the threshold reads 1 and `irq` is low.
- R2: A threshold write keeps only the low log2(DEPTH) bits of `wr_data`. Writing 0xFFFF reads back DEPTH-1, and writing 0x13 to a depth-8 unit reads back 3.
- R3: Status bit 2 becomes 1 one clock after a cycle in which the entry count is strictly below the threshold. A count equal to the threshold does not set it. While the condition holds, a clear written to the bit has no effect.
- R4: Writing the status register (`wr_stb[0]`) clears exactly the bits written as 1 and leaves every other bit unchanged.
- R5: A push while the FIFO holds DEPTH entries is dropped, so the contents do not change, and status bit 3 becomes 1 on the next clock.
- R6: Status bit 4 becomes 1 one clock after any cycle with `rx_level` non-zero.
- R7: Status bit 1 becomes 1 one clock after a cycle with `mode_fault` high.
- R8: An enable write (`wr_stb[1]`) sets the mask bits written as 1. A disable write (`wr_stb[2]`) clears them. The mask is read with `rd_sel`=1, the status with `rd_sel`=0 and the threshold with `rd_sel`=2.
- R9: When enable and disable strobes arrive in the same cycle, disable wins and the written bits end up cleared in the mask.
- R10: `irq` is high exactly when some status bit is 1 and its mask bit is 1. Disabling a source drops `irq` without altering the status.
- R11: Popped words come out in push order. `tx_empty` is high when no entries remain, and `pop_data` shows the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push | input | 1 | Enqueue `push_data` |
| push_data | input | DW | Word to enqueue |
| pop | input | 1 | Dequeue the head entry |
| pop_data | output | DW | Head entry of the queue |
| tx_empty | output | 1 | Queue holds no entries |
| rx_level | input | RXW | Receive-side occupancy |
| mode_fault | input | 1 | Mode-fault event pulse |
| wr_stb | input | 4 | Write strobes: 0 status clear, 1 enable, 2 disable, 3 threshold |
| wr_data | input | RDW | Write data shared by all strobes |
| rd_sel | input | 2 | Read select: 0 status, 1 mask, 2 threshold, 3 zero |
| rd_data | output | RDW | Read data for `rd_sel` |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest cases to reach are at the edges of the watermark comparison and of the disable precedence rule. The count must sit exactly at the threshold for one cycle and then drop below it, with status cleared just before. The bench sets the threshold to 2, pushes three words and clears the status. It then pops one word per cycle and checks that bit 2 stays clear while the count equals the threshold and sets only after the count falls to 1. For the same-cycle rule, one register write raises both the enable and the disable strobes with the same data while the mask already holds an enabled bit, and the mask readback must show that bit cleared. Setting the threshold to 0 keeps the watermark source quiet, so the other status bits can be studied in isolation.

// File: rtl/txwm_pkg.sv
package txwm_pkg;
   localparam int unsigned IRQ_W = 7;
   typedef logic [IRQ_W-1:0] irq_vec_t;

   // event bit positions (software decodes these)
   localparam int unsigned IB_FAULT  = 1;
   localparam int unsigned IB_TXLOW  = 2;
   localparam int unsigned IB_TXFULL = 3;
   localparam int unsigned IB_RXNE   = 4;
   localparam irq_vec_t    IRQ_ALL   = 7'h7F;

   // write strobe lanes
   localparam int unsigned WS_STS = 0;
   localparam int unsigned WS_EN  = 1;
   localparam int unsigned WS_DIS = 2;
   localparam int unsigned WS_THR = 3;

   typedef enum logic [1:0] {
      RS_STATUS = 2'd0,
      RS_MASK   = 2'd1,
      RS_THRESH = 2'd2,
      RS_NONE   = 2'd3
   } rd_sel_e;
endpackage

// File: rtl/txwm_fifo.sv
module txwm_fifo #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned DW    = 8,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [CW-1:0] cnt,
   output logic          full,
   output logic          empty
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;
   logic          do_wr, do_rd;

   assign full  = (cnt_q == CW'(DEPTH));
   assign empty = (cnt_q == '0);
   assign do_wr = push && !full;
   assign do_rd = pop && !empty;
   assign head  = mem[rp_q];
   assign cnt   = cnt_q;

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp_q] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_wr) wp_q <= wp_q + AW'(1);
         if (do_rd) rp_q <= rp_q + AW'(1);
         case ({do_wr, do_rd})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/txwm_evt.sv
module txwm_evt
   import txwm_pkg::*;
#(
   parameter irq_vec_t ENA_RST = 7'h06
) (
   input  logic     clk,
   input  logic     rst_n,
   input  irq_vec_t src,
   input  logic     clr_wr,
   input  logic     en_wr,
   input  logic     dis_wr,
   input  irq_vec_t wdata,
   output irq_vec_t sts,
   output irq_vec_t msk,
   output logic     irq
);
   irq_vec_t msk_q;

   // one sticky cell per event bit; a new event wins over a same-cycle clear
   for (genvar i = 0; i < IRQ_W; i++) begin : g_cell
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bit_q <= 1'b0;
         else if (src[i])
            bit_q <= 1'b1;
         else if (clr_wr && wdata[i])
            bit_q <= 1'b0;
      end
      assign sts[i] = bit_q;
   end

   // set first, then clear: disable dominates
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         msk_q <= ENA_RST & IRQ_ALL;
      else
         msk_q <= (msk_q | (en_wr ? wdata : '0)) & ~(dis_wr ? wdata : '0);
   end

   assign msk = msk_q;
   assign irq = |(sts & msk_q);
endmodule

// File: rtl/txwm_irq_unit.sv
module txwm_irq_unit
   import txwm_pkg::*;
#(
   parameter int unsigned DEPTH   = 8,
   parameter int unsigned DW      = 8,
   parameter int unsigned RXW     = 4,
   parameter int unsigned RDW     = 16,
   parameter irq_vec_t    ENA_RST = 7'h06
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           push,
   input  logic [DW-1:0]  push_data,
   input  logic           pop,
   output logic [DW-1:0]  pop_data,
   output logic           tx_empty,
   input  logic [RXW-1:0] rx_level,
   input  logic           mode_fault,
   input  logic [3:0]     wr_stb,
   input  logic [RDW-1:0] wr_data,
   input  logic [1:0]     rd_sel,
   output logic [RDW-1:0] rd_data,
   output logic           irq
);
   localparam int unsigned TW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (RDW < IRQ_W || RDW < TW) begin : g_bad_rdw
      $error("RDW too narrow for status or threshold");
   end

   logic [CW-1:0] tx_cnt;
   logic          tx_full;
   logic [TW-1:0] thr_q;
   irq_vec_t      src, sts_q, msk_q;
   logic          unused_wr_hi;

   txwm_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
      .pop(pop), .head(pop_data), .cnt(tx_cnt), .full(tx_full),
      .empty(tx_empty)
   );

   // threshold keeps only the bits needed for DEPTH-1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         thr_q <= TW'(1);
      else if (wr_stb[WS_THR])
         thr_q <= wr_data[TW-1:0];
   end
   assign unused_wr_hi = &{1'b0, wr_data[RDW-1:TW]};

   always_comb begin
      src            = '0;
      src[IB_FAULT]  = mode_fault;
      src[IB_TXLOW]  = (tx_cnt < CW'(thr_q));
      src[IB_TXFULL] = push && tx_full;
      src[IB_RXNE]   = (rx_level != '0);
   end

   txwm_evt #(.ENA_RST(ENA_RST)) u_evt (
      .clk(clk), .rst_n(rst_n), .src(src),
      .clr_wr(wr_stb[WS_STS]), .en_wr(wr_stb[WS_EN]), .dis_wr(wr_stb[WS_DIS]),
      .wdata(wr_data[IRQ_W-1:0]), .sts(sts_q), .msk(msk_q), .irq(irq)
   );

   always_comb begin
      case (rd_sel_e'(rd_sel))
         RS_STATUS: rd_data = {{(RDW-IRQ_W){1'b0}}, sts_q};
         RS_MASK:   rd_data = {{(RDW-IRQ_W){1'b0}}, msk_q};
         RS_THRESH: rd_data = {{(RDW-TW){1'b0}}, thr_q};
         default:   rd_data = '0;
      endcase
   end
endmodule

// File: rtl/txwm_irq_unit_chk.sv
module txwm_irq_unit_chk
   import txwm_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned RDW   = 16,
   localparam int unsigned TW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           push,
   input logic           mode_fault,
   input logic           rx_nz,
   input logic [3:0]     wr_stb,
   input logic [RDW-1:0] wr_data,
   input logic [CW-1:0]  cnt,
   input logic [TW-1:0]  thr,
   input irq_vec_t       sts,
   input irq_vec_t       msk
);
   // R3
   txlow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt < CW'(thr)) |=> sts[IB_TXLOW]);
   // R5
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && cnt == CW'(DEPTH)) |=> (sts[IB_TXFULL] && cnt <= CW'(DEPTH)));
   // R11
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   // R6
   rxne_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_nz |=> sts[IB_RXNE]);
   // R7
   fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_fault |=> sts[IB_FAULT]);
   // R9
   dis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb[WS_DIS] |=> ((msk & $past(wr_data[IRQ_W-1:0])) == '0));
   // R4
   clr_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb[WS_STS] && !mode_fault && !push && !rx_nz && !(cnt < CW'(thr)))
      |=> (sts == ($past(sts) & ~$past(wr_data[IRQ_W-1:0]))));
endmodule

bind txwm_irq_unit txwm_irq_unit_chk #(.DEPTH(DEPTH), .RDW(RDW)) u_chk (
   .clk(clk), .rst_n(rst_n), .push(push), .mode_fault(mode_fault),
   .rx_nz(rx_level != '0), .wr_stb(wr_stb), .wr_data(wr_data),
   .cnt(tx_cnt), .thr(thr_q), .sts(sts_q), .msk(msk_q)
);

// File: tb/txwm_irq_unit_bench.sv
module txwm_irq_unit_bench;
   localparam int DEPTH = 8;
   localparam int DW    = 8;
   localparam int RXW   = 4;
   localparam int RDW   = 16;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           push = 1'b0;
   logic [DW-1:0]  push_data = '0;
   logic           pop = 1'b0;
   logic [DW-1:0]  pop_data;
   logic           tx_empty;
   logic [RXW-1:0] rx_level = '0;
   logic           mode_fault = 1'b0;
   logic [3:0]     wr_stb = '0;
   logic [RDW-1:0] wr_data = '0;
   logic [1:0]     rd_sel = '0;
   logic [RDW-1:0] rd_data;
   logic           irq;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   txwm_irq_unit #(.DEPTH(DEPTH), .DW(DW), .RXW(RXW), .RDW(RDW)) u_txwm_irq_unit (
      .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
      .pop(pop), .pop_data(pop_data), .tx_empty(tx_empty),
      .rx_level(rx_level), .mode_fault(mode_fault),
      .wr_stb(wr_stb), .wr_data(wr_data), .rd_sel(rd_sel),
      .rd_data(rd_data), .irq(irq)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] sel, output int v);
      rd_sel = sel;
      #1;
      v = int'(rd_data);
   endtask

   task automatic wr(input logic [3:0] stb, input logic [RDW-1:0] d);
      @(negedge clk);
      wr_stb = stb;
      wr_data = d;
      @(negedge clk);
      wr_stb = '0;
   endtask

   task automatic do_push(input logic [DW-1:0] d);
      @(negedge clk);
      push = 1'b1;
      push_data = d;
      @(negedge clk);
      push = 1'b0;
   endtask

   task automatic do_pop();
      @(negedge clk);
      pop = 1'b1;
      @(negedge clk);
      pop = 1'b0;
   endtask

   task automatic t_reset();
      int v;
      @(negedge clk);
      rd(2'd0, v); check("R1 status", v, 0);
      rd(2'd1, v); check("R1 mask", v, 'h06);
      rd(2'd2, v); check("R1 thresh", v, 1);
      check("R1 irq", int'(irq), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_thresh();
      int v;
      wr(4'b1000, 16'hFFFF);
      rd(2'd2, v); check("R2 all ones", v, DEPTH - 1);
      wr(4'b1000, 16'h0013);
      rd(2'd2, v); check("R2 truncate", v, 3);
   endtask

   task automatic t_below();
      int v;
      wr(4'b1000, 16'd2);
      for (int i = 0; i < 3; i++) do_push(DW'(i));
      wr(4'b0001, 16'h007F);
      rd(2'd0, v); check("R4 clear all", v, 0);
      do_pop();                       // count 3 -> 2
      rd(2'd0, v); check("R3 above", v & 'h04, 0);
      do_pop();                       // count 2 -> 1, edge saw count 2
      rd(2'd0, v); check("R3 equal", v & 'h04, 0);
      @(negedge clk);                 // edge saw count 1
      rd(2'd0, v); check("R3 below", v & 'h04, 'h04);
      wr(4'b0001, 16'h0004);
      rd(2'd0, v); check("R3 clear ignored", v & 'h04, 'h04);
      do_pop();
      check("R11 drained", int'(tx_empty), 1);
   endtask

   task automatic t_events();
      int v;
      wr(4'b1000, 16'd0);             // quiet watermark source
      wr(4'b0001, 16'h007F);
      @(negedge clk);
      mode_fault = 1'b1;
      rx_level = 4'd3;
      @(negedge clk);
      mode_fault = 1'b0;
      rx_level = '0;
      rd(2'd0, v);
      check("R7 fault", v & 'h02, 'h02);
      check("R6 rx", v & 'h10, 'h10);
      wr(4'b0001, 16'h0010);
      rd(2'd0, v); check("R4 selective", v, 'h02);
      wr(4'b0001, 16'h0002);
      rd(2'd0, v); check("R4 cleared", v, 0);
   endtask

   task automatic t_full();
      int v;
      for (int i = 0; i < DEPTH; i++) do_push(DW'('hA0 + i));
      rd(2'd0, v); check("R5 not yet", v, 0);
      do_push(8'hEE);
      rd(2'd0, v); check("R5 full flag", v, 'h08);
      for (int i = 0; i < DEPTH; i++) begin
         check("R11 order", int'(pop_data), 'hA0 + i);
         do_pop();
      end
      check("R5 dropped", int'(tx_empty), 1);
      wr(4'b0001, 16'h007F);
   endtask

   task automatic t_mask();
      int v;
      wr(4'b0010, 16'h0018);
      rd(2'd1, v); check("R8 enable", v, 'h1E);
      wr(4'b0100, 16'h0006);
      rd(2'd1, v); check("R8 disable", v, 'h18);
      wr(4'b0010, 16'h0001);
      wr(4'b0110, 16'h0021);
      rd(2'd1, v); check("R9 both", v, 'h18);
   endtask

   task automatic t_irq();
      int v;
      wr(4'b0100, 16'h007F);
      wr(4'b0001, 16'h007F);
      check("R10 idle", int'(irq), 0);
      @(negedge clk);
      rx_level = 4'd1;
      @(negedge clk);
      rx_level = '0;
      check("R10 masked", int'(irq), 0);
      wr(4'b0010, 16'h0010);
      check("R10 enabled", int'(irq), 1);
      wr(4'b0100, 16'h0010);
      check("R10 disabled", int'(irq), 0);
      rd(2'd0, v); check("R10 status kept", v, 'h10);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_thresh();
      t_below();
      t_events();
      t_full();
      t_mask();
      t_irq();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule